// File: doc/BRIEF.md
# DC-Balanced Twelve-Bit Frame Encoder

This block turns a stream of host bytes into a continuous serial bit stream made of 12-bit frames. Each frame carries one payload byte and a flag that marks the byte as data or as a control word. Both the invert flag and the data/control flag are sent next to their complements. The block tracks a signed running disparity. For each new frame it decides whether to send the payload inverted, so that the long-run DC content of the line stays near zero.

The host side is a valid/ready interface backed by a single holding register. `in_ready` is high exactly when the register is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the host must keep offering its byte, and nothing is accepted until the held byte has gone into a frame. The serial side advances by one bit on each clock edge where `bit_tick` is high. When a frame slot opens on a tick and no host byte is held, the block sends the idle control word (payload 0x00, control). The line therefore never stalls and always carries a minimum transition density.

Top module: `dcb_frame_encoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `ser_out`, `frame_load` and `host_ack` are 0, `in_ready` is 1, `slot_open` is 1 and the running disparity is zero.
- R2: A frame goes out in this order: complement of the invert flag, the invert flag, payload bits 0 through 7 (least significant first), the data/control flag, then its complement.
- R3: `in_kind` = 1 marks the byte as data and 0 marks it as control. The flag is sent (true or inverted per R6) in the data/control position.
- R4: When a frame is loaded and no host byte is held, the frame carries payload 0x00 with data/control = 0. From reset the first two idle frames are 1,0,0,0,0,0,0,0,0,0,0,1 and 0,1,1,1,1,1,1,1,1,1,1,0.
- R5: Payload disparity is (+1 per one bit, −1 per zero bit). The invert flag is 0, and the disparity is added to the running sum, when the disparity and the running sum differ in sign (negative versus zero-or-more). Otherwise the flag is 1 and the disparity is subtracted.
- R6: With the invert flag at 1, the payload byte and the data/control flag are both sent complemented.
- R7: `in_ready` is high exactly when no byte is held. A byte is captured on `in_valid && in_ready` and held unchanged until it is loaded into a frame.
- R8: `ser_out` changes only on a clock edge where `bit_tick` was high, and one tick moves it by exactly one bit.
- R9: `slot_open` is high while no frame has started yet or while the last bit of the current frame is on the line. A tick with `slot_open` high loads a new frame, and `frame_load` is high for the one cycle in which that frame's first bit appears.
- R10: `host_ack` is high for one cycle, together with `frame_load`, in the cycle the frame carrying a held host byte starts.
- R11: The running disparity always stays within ±8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host offers a byte |
| in_ready | output | 1 | Holding register is empty |
| in_data | input | 8 | Host payload byte |
| in_kind | input | 1 | 1 = data, 0 = control |
| bit_tick | input | 1 | Advance the serial line by one bit |
| slot_open | output | 1 | Next tick will load a new frame |
| ser_out | output | 1 | Serial line |
| frame_load | output | 1 | First bit of a new frame is on the line |
| host_ack | output | 1 | Frame just started carries the held host byte |

## Verification
A wrong running disparity or a wrong inversion choice does not stay hidden. It flips the invert-flag pair in the very next frame, and that pair reaches `ser_out` within two ticks of the following `frame_load`. A fault in the holding register shows up in the same cycle as a wrong `in_ready`, or one frame later as an idle frame where a host byte was due. Because the bench model predicts every output on every clock, a fault in the bit counter appears as a misplaced `frame_load` within one frame of ticks.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  localparam logic KIND_CTRL = 1'b0;
  localparam logic KIND_DATA = 1'b1;
endpackage

// File: rtl/dcb_hold.sv
module dcb_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_kind,
  output logic              in_ready,
  input  logic              take,
  output logic              held_valid,
  output logic [BYTE_W-1:0] held_byte,
  output logic              held_kind
);
  logic accept;

  assign in_ready = !held_valid;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_valid <= 1'b0;
      held_byte  <= '0;
      held_kind  <= 1'b0;
    end else if (accept) begin
      held_valid <= 1'b1;
      held_byte  <= in_data;
      held_kind  <= in_kind;
    end else if (take) begin
      held_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/dcb_balance.sv
module dcb_balance #(
  parameter int BYTE_W = 8,
  parameter int SUM_W  = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit,
  input  logic [BYTE_W-1:0]       pay_byte,
  input  logic                    pay_kind,
  output logic [BYTE_W+3:0]       frame_bits,
  output logic signed [SUM_W-1:0] run_sum
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]        ones;
  logic signed [SUM_W-1:0] ones_s;
  logic signed [SUM_W-1:0] disp;
  logic                    invert;
  logic [BYTE_W-1:0]       sent_byte;
  logic                    sent_kind;

  always_comb begin
    ones = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      ones = ones + CNT_W'(pay_byte[i]);
    end
  end

  assign ones_s = SUM_W'(ones);
  assign disp   = (ones_s <<< 1) - $signed(SUM_W'(BYTE_W));
  // same sign class (both negative or both non-negative) -> invert
  assign invert = (disp[SUM_W-1] == run_sum[SUM_W-1]);

  assign sent_byte = invert ? ~pay_byte : pay_byte;
  assign sent_kind = invert ? ~pay_kind : pay_kind;

  // bit 0 leaves first
  assign frame_bits = {~sent_kind, sent_kind, sent_byte, invert, ~invert};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_sum <= '0;
    end else if (commit) begin
      run_sum <= invert ? (run_sum - disp) : (run_sum + disp);
    end
  end
endmodule

// File: rtl/dcb_shifter.sv
module dcb_shifter #(
  parameter int FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_tick,
  input  logic [FRAME_W-1:0] frame_bits,
  output logic               slot_open,
  output logic               load,
  output logic               ser_out,
  output logic               frame_load
);
  localparam int LEFT_W = $clog2(FRAME_W);

  logic [FRAME_W-2:0] shreg;
  logic [LEFT_W-1:0]  left;
  logic               empty;

  assign slot_open = empty || (left == '0);
  assign load      = bit_tick && slot_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      left       <= '0;
      empty      <= 1'b1;
      ser_out    <= 1'b0;
      frame_load <= 1'b0;
    end else begin
      frame_load <= load;
      if (load) begin
        ser_out <= frame_bits[0];
        shreg   <= frame_bits[FRAME_W-1:1];
        left    <= LEFT_W'(FRAME_W - 1);
        empty   <= 1'b0;
      end else if (bit_tick) begin
        ser_out <= shreg[0];
        shreg   <= shreg >> 1;
        left    <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dcb_frame_encoder.sv
module dcb_frame_encoder #(
  parameter int BYTE_W = 8,
  parameter int SUM_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_kind,
  input  logic              bit_tick,
  output logic              slot_open,
  output logic              ser_out,
  output logic              frame_load,
  output logic              host_ack
);
  import dcb_pkg::*;

  localparam int FRAME_W = BYTE_W + 4;

  logic                    held_valid;
  logic [BYTE_W-1:0]       held_byte;
  logic                    held_kind;
  logic                    load;
  logic                    take;
  logic [BYTE_W-1:0]       pay_byte;
  logic                    pay_kind;
  logic [FRAME_W-1:0]      frame_bits;
  logic signed [SUM_W-1:0] run_sum;

  assign take     = load && held_valid;
  assign pay_byte = held_valid ? held_byte : '0;
  assign pay_kind = held_valid ? held_kind : KIND_CTRL;

  dcb_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_kind   (in_kind),
    .in_ready  (in_ready),
    .take      (take),
    .held_valid(held_valid),
    .held_byte (held_byte),
    .held_kind (held_kind)
  );

  dcb_balance #(.BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_bal (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (load),
    .pay_byte  (pay_byte),
    .pay_kind  (pay_kind),
    .frame_bits(frame_bits),
    .run_sum   (run_sum)
  );

  dcb_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .frame_bits(frame_bits),
    .slot_open (slot_open),
    .load      (load),
    .ser_out   (ser_out),
    .frame_load(frame_load)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) host_ack <= 1'b0;
    else        host_ack <= take;
  end
endmodule

// File: rtl/dcb_checker.sv
module dcb_checker #(
  parameter int BYTE_W = 8,
  parameter int SUM_W  = 6
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bit_tick,
  input logic                    slot_open,
  input logic                    frame_load,
  input logic                    host_ack,
  input logic                    in_ready,
  input logic                    ser_out,
  input logic signed [SUM_W-1:0] run_sum
);
  AST_SUM_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(run_sum) <= BYTE_W) && (int'(run_sum) >= -BYTE_W)); // R11

  AST_LINE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> $stable(ser_out)); // R8

  AST_LOAD_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |-> $past(bit_tick && slot_open)); // R9

  AST_ACK_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> frame_load); // R10

  AST_ACK_NEEDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(!in_ready)); // R7

  AST_SINGLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_load |=> !frame_load || $past(bit_tick)); // R9
endmodule

bind dcb_frame_encoder dcb_checker #(.BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_tick  (bit_tick),
  .slot_open (slot_open),
  .frame_load(frame_load),
  .host_ack  (host_ack),
  .in_ready  (in_ready),
  .ser_out   (ser_out),
  .run_sum   (run_sum)
);

// File: tb/test_dcb_frame_encoder.sv
module test_dcb_frame_encoder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = '0;
  logic       in_kind = 1'b0;
  logic       bit_tick = 1'b0;
  logic       slot_open;
  logic       ser_out;
  logic       frame_load;
  logic       host_ack;

  int n_checks = 0;
  int n_fail   = 0;
  bit cmp_en   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcb_frame_encoder i_dcb_frame_encoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_kind(in_kind), .bit_tick(bit_tick),
    .slot_open(slot_open), .ser_out(ser_out), .frame_load(frame_load),
    .host_ack(host_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit   m_hold_v;
  int   m_hold_b;
  bit   m_hold_k;
  int   m_sum;
  bit   m_bits[$];
  int   m_left;
  bit   m_empty;
  bit   m_out;
  bit   m_load;
  bit   m_ack;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold_v = 0; m_hold_b = 0; m_hold_k = 0; m_sum = 0;
      m_bits = {}; m_left = 0; m_empty = 1; m_out = 0; m_load = 0; m_ack = 0;
    end else begin
      bit acc;
      acc = in_valid && !m_hold_v;
      m_load = 0;
      m_ack  = 0;
      if (bit_tick) begin
        if (m_empty || m_left == 0) begin
          int b; bit k; int d; bit inv; int pb; bit dk;
          if (m_hold_v) begin
            b = m_hold_b; k = m_hold_k; m_hold_v = 0; m_ack = 1;
          end else begin
            b = 0; k = 0;
          end
          d = 0;
          for (int i = 0; i < 8; i++) d += b[i] ? 1 : -1;
          if ((d < 0 && m_sum >= 0) || (d >= 0 && m_sum < 0)) begin
            inv = 0; m_sum += d;
          end else begin
            inv = 1; m_sum -= d;
          end
          pb = inv ? (~b & 8'hFF) : b;
          dk = inv ? !k : k;
          m_bits = {};
          m_bits.push_back(!inv);
          m_bits.push_back(inv);
          for (int i = 0; i < 8; i++) m_bits.push_back(pb[i]);
          m_bits.push_back(dk);
          m_bits.push_back(!dk);
          m_out = m_bits.pop_front();
          m_left = 11; m_empty = 0; m_load = 1;
        end else begin
          m_out = m_bits.pop_front();
          m_left--;
        end
      end
      if (acc) begin
        m_hold_v = 1; m_hold_b = in_data; m_hold_k = in_kind;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      check(ser_out == m_out, "R2/R5/R6 ser_out", ser_out, m_out);
      check(in_ready == !m_hold_v, "R7 in_ready", in_ready, !m_hold_v);
      check(frame_load == m_load, "R9 frame_load", frame_load, m_load);
      check(host_ack == m_ack, "R10 host_ack", host_ack, m_ack);
      check(slot_open == (m_empty || m_left == 0), "R9 slot_open",
            slot_open, (m_empty || m_left == 0));
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    bit idle_exp[24];
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ser_out == 0, "R1 ser_out", ser_out, 0);
    check(in_ready == 1, "R1 in_ready", in_ready, 1);
    check(slot_open == 1, "R1 slot_open", slot_open, 1);
    check(frame_load == 0, "R1 frame_load", frame_load, 0);
    check(host_ack == 0, "R1 host_ack", host_ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(slot_open == 1 && ser_out == 0, "R1 after release", ser_out, 0);
    cmp_en = 1;
    // R4 R2 two idle frames with a tick every cycle
    for (int i = 0; i < 24; i++) idle_exp[i] = 0;
    idle_exp[0] = 1; idle_exp[11] = 1;
    for (int i = 13; i < 23; i++) idle_exp[i] = 1;
    bit_tick = 1'b1;
    @(negedge clk);
    check(frame_load == 1, "R4 first idle load", frame_load, 1);
    for (int i = 0; i < 24; i++) begin
      check(ser_out == idle_exp[i], "R4 idle bit", ser_out, idle_exp[i]);
      @(negedge clk);
    end
    // R8 line holds without ticks
    bit_tick = 1'b0;
    begin
      bit held;
      @(negedge clk);
      held = ser_out;
      repeat (5) @(negedge clk);
      check(ser_out == held, "R8 no tick hold", ser_out, held);
    end
    // R3 R6 directed data 0xFF, then control 0x0F; R7 back-pressure
    in_valid = 1; in_data = 8'hFF; in_kind = 1;
    @(negedge clk);
    in_data = 8'h0F; in_kind = 0;
    repeat (6) @(negedge clk);
    check(in_ready == 0, "R7 held blocks", in_ready, 0);
    for (int c = 0; c < 60; c++) begin
      bit_tick = (c % 2) == 0;
      @(negedge clk);
    end
    in_valid = 0;
    // random traffic, varied tick density
    for (int c = 0; c < 30000; c++) begin
      int ph;
      ph = c / 5000;
      bit_tick = (ph % 3 == 0) ? 1'b1 : (($urandom % (ph + 2)) == 0);
      in_valid = ($urandom % 4) != 0;
      in_data  = 8'($urandom);
      in_kind  = 1'($urandom);
      @(negedge clk);
    end
    // mid-run reset returns to R1 state
    rst_n = 0; cmp_en = 0;
    @(negedge clk);
    check(in_ready == 1 && slot_open == 1 && ser_out == 0 && frame_load == 0,
          "R1 re-reset", ser_out, 0);
    summary();
  end
endmodule